// File: doc/BRIEF.md
# UART Interrupt Raw/Mask/Clear Hub

This block gathers the nine event sources of a serial port into one interrupt request. Each source delivers a one-cycle pulse. The pulse latches into a sticky pending bit that stays set until software acknowledges it. A software-written mask selects which pending bits may assert the request line. The masked view is also readable, so a handler can see at once which enabled sources need service.

Software uses a small register port with a byte address, a write strobe, write data and combinational read data. The pending word, the masked word and the mask are all readable. Software acknowledges events through a separate write-one-to-acknowledge location. The block does not generate the events. Whichever logic produces them drives the pulse vector directly.

Top module: `uart_irq_hub`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every readable location returns zero and `irq` is low.
- R2: A 1 on `evt_pulse[i]` at a rising clock edge sets pending bit i from the next cycle. The bit stays set until it is acknowledged. It is read at byte address 0x4.
- R3: The pending and mask bit positions are fixed, and event decoders rely on them: bit 0 receive-buffer level reached, bit 1 transmit-buffer low, bit 2 parity error, bit 3 framing error, bit 4 receive overrun, bit 5 data-set-ready change, bit 6 clear-to-send change, bit 7 break or start error, bit 8 receive idle time-out.
- R4: Address 0x8 reads the bitwise AND of the pending word and the mask word.
- R5: The mask word is written and read at address 0xC. Its bits above the source count read as zero.
- R6: A write at address 0x10 clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R7: If a source pulses in the same cycle that its pending bit is acknowledged, the bit stays set.
- R8: `irq` is high exactly when at least one bit of the masked word is 1.
- R9: Address 0x10 always reads zero. A write to 0x4, 0x8 or any unmapped address changes no state. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: nine sources, an 8-bit address and a 32-bit read word. With these values every source position, the zero-filled upper read bits and the exact offsets 0x4 through 0x10 can be checked, along with unmapped neighbours such as 0x0 and 0x14. Directed steps walk each source bit and collide a pulse with its own acknowledge. A long random run then mixes sparse pulses with mask writes, acknowledge writes and ignored writes, so every address sees both empty and crowded pending words.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   // Fixed source positions; event decoders depend on this order.
   typedef enum int {
      SRC_RX_LEVEL   = 0,
      SRC_TX_LOW     = 1,
      SRC_PARITY     = 2,
      SRC_FRAMING    = 3,
      SRC_RX_OVERRUN = 4,
      SRC_DSR_EDGE   = 5,
      SRC_CTS_EDGE   = 6,
      SRC_BREAK      = 7,
      SRC_RX_IDLE    = 8
   } uirq_src_e;

   localparam int UIRQ_SRC_COUNT = 9;

   localparam int UIRQ_OFS_PEND = 'h04;
   localparam int UIRQ_OFS_MASKED = 'h08;
   localparam int UIRQ_OFS_MASK = 'h0C;
   localparam int UIRQ_OFS_ACK = 'h10;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            q_o[i] <= 1'b0;
         else if (set_i[i])
            q_o[i] <= 1'b1;
         else if (clr_i[i])
            q_o[i] <= 1'b0;
      end

      // R2: a pulse leaves its bit set on the next cycle.
      assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);

      // R7: a pulse that collides with an acknowledge still wins.
      assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[i] && clr_i[i]) |=> q_o[i]);

      // R6: an acknowledge with no pulse drops the bit.
      assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]);

      // R2: without pulse or acknowledge the bit holds.
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
   end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else if (we_i)
         q_o <= wdata_i;
   end

   // R5: a mask write lands in the next cycle.
   assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q_o == $past(wdata_i)));

   // R9: without a mask write the mask holds.
   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
   parameter int N = 9,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int OFS_PEND = 'h04,
   parameter int OFS_MASKED = 'h08,
   parameter int OFS_MASK = 'h0C
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [N-1:0]      pend_i,
   input  logic [N-1:0]      masked_i,
   input  logic [N-1:0]      mask_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

   // The acknowledge location and unmapped addresses fall to zero.
   always_comb begin
      rdata_o = '0;
      if (addr_i == A_PEND)
         rdata_o = DATA_W'(pend_i);
      else if (addr_i == A_MASKED)
         rdata_o = DATA_W'(masked_i);
      else if (addr_i == A_MASK)
         rdata_o = DATA_W'(mask_i);
   end

endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
   import uirq_pkg::*;
#(
   parameter int NUM_SRC = UIRQ_SRC_COUNT,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int OFS_PEND = UIRQ_OFS_PEND,
   parameter int OFS_MASKED = UIRQ_OFS_MASKED,
   parameter int OFS_MASK = UIRQ_OFS_MASK,
   parameter int OFS_ACK = UIRQ_OFS_ACK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_pulse,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [NUM_SRC-1:0] reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq
);

   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
   localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFS_ACK);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks.
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("uart_irq_hub: NUM_SRC must lie in 1..DATA_W");
   end
   if (OFS_PEND >= ADDR_SPAN || OFS_MASKED >= ADDR_SPAN ||
       OFS_MASK >= ADDR_SPAN || OFS_ACK >= ADDR_SPAN) begin : g_bad_ofs
      $error("uart_irq_hub: an offset does not fit in ADDR_W");
   end
   if (OFS_PEND == OFS_MASKED || OFS_PEND == OFS_MASK || OFS_PEND == OFS_ACK ||
       OFS_MASKED == OFS_MASK || OFS_MASKED == OFS_ACK || OFS_MASK == OFS_ACK)
   begin : g_dup_ofs
      $error("uart_irq_hub: register offsets must be distinct");
   end

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] masked;
   logic [NUM_SRC-1:0] ack_vec;
   logic               mask_we;

   assign mask_we = reg_wr && (reg_addr == A_MASK);
   assign ack_vec = (reg_wr && (reg_addr == A_ACK)) ? reg_wdata : '0;

   irq_sticky_bank #(.N(NUM_SRC)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_pulse),
      .clr_i (ack_vec),
      .q_o   (pend_q)
   );

   irq_mask_reg #(.N(NUM_SRC)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mask_we),
      .wdata_i (reg_wdata),
      .q_o     (mask_q)
   );

   assign masked = pend_q & mask_q;
   assign irq = |masked;

   irq_read_mux #(
      .N          (NUM_SRC),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .OFS_PEND   (OFS_PEND),
      .OFS_MASKED (OFS_MASKED),
      .OFS_MASK   (OFS_MASK)
   ) u_rd (
      .addr_i   (reg_addr),
      .pend_i   (pend_q),
      .masked_i (masked),
      .mask_i   (mask_q),
      .rdata_o  (reg_rdata)
   );

   // R4: the masked read never shows a bit the mask disables.
   assert_masked_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_MASKED) |-> ((reg_rdata & ~DATA_W'(mask_q)) == '0));

   // R8: a nonzero masked read implies a raised request.
   assert_irq_follows_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr == A_MASKED) && (reg_rdata != '0)) |-> irq);

   // R8: the request is never raised with an all-zero mask.
   assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != '0));

   // R9: the acknowledge location reads zero.
   assert_ack_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_ACK) |-> (reg_rdata == '0));

endmodule

// File: tb/uart_irq_hub_test.sv
`timescale 1ns/1ps
module uart_irq_hub_test;

   localparam int N = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_pulse = '0;
   logic [7:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [N-1:0]  reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // Reference state
   logic [N-1:0] m_pend = '0;
   logic [N-1:0] m_mask = '0;

   always #2.5 clk = ~clk;

   uart_irq_hub uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h04:   return 32'(m_pend);
         8'h08:   return 32'(m_pend & m_mask);
         8'h0C:   return 32'(m_mask);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_for(input logic [7:0] a);
      case (a)
         8'h04:   return "R2 pending read";
         8'h08:   return "R4 masked read";
         8'h0C:   return "R5 mask read";
         8'h10:   return "R9 ack read";
         default: return "R9 unmapped read";
      endcase
   endfunction

   // One cycle: drive at the falling edge, compare, then advance the model at the rising edge.
   task automatic step(input logic [N-1:0] e, input logic [7:0] a, input logic w, input logic [N-1:0] d);
      evt_pulse = e;
      reg_addr = a;
      reg_wr = w;
      reg_wdata = d;
      #1;
      if (!rst_n) begin
         check("R1 reset read", reg_rdata, 32'h0);
         check("R1 reset irq", {31'h0, irq}, 32'h0);
      end else begin
         check(tag_for(a), reg_rdata, model_read(a));
         check("R8 irq", {31'h0, irq}, {31'h0, |(m_pend & m_mask)});
      end
      @(posedge clk);
      if (!rst_n) begin
         m_pend = '0;
         m_mask = '0;
      end else begin
         if (w && a == 8'h10) m_pend = m_pend & ~d;
         m_pend = m_pend | e;
         if (w && a == 8'h0C) m_mask = d;
      end
      @(negedge clk);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset behaviour, including pulses and writes during reset
      step('1, 8'h04, 1'b0, '0);
      step('0, 8'h0C, 1'b1, '1);
      step('1, 8'h08, 1'b0, '0);
      rst_n = 1'b1;
      step('0, 8'h04, 1'b0, '0);
      step('0, 8'h0C, 1'b0, '0);
      step('0, 8'h08, 1'b0, '0);

      // R3: each source lands in its own bit position
      for (int i = 0; i < N; i++) begin
         step(N'(1) << i, 8'h04, 1'b0, '0);
         #0;
         check($sformatf("R3 source %0d position", i), reg_rdata, 32'(1) << i);
         step('0, 8'h10, 1'b1, '1);
      end

      // R5: mask write, upper bits read zero
      step('0, 8'h0C, 1'b1, 9'h155);
      check("R5 mask readback", reg_rdata, 32'h155);
      step('0, 8'h0C, 1'b1, '1);
      check("R5 full mask", reg_rdata, 32'h1FF);

      // R6: partial acknowledge keeps the 0-written bits
      step(9'h0F0, 8'h04, 1'b0, '0);
      step('0, 8'h10, 1'b1, 9'h030);
      step('0, 8'h04, 1'b0, '0);
      check("R6 partial ack", reg_rdata, 32'h0C0);

      // R7: a pulse colliding with its acknowledge survives
      step(9'h004, 8'h10, 1'b1, 9'h0C4);
      step('0, 8'h04, 1'b0, '0);
      check("R7 set beats clear", reg_rdata, 32'h004);

      // R9: writes to read-only or unmapped locations change nothing
      step('0, 8'h04, 1'b1, '1);
      step('0, 8'h08, 1'b1, '1);
      step('0, 8'h14, 1'b1, '1);
      step('0, 8'h00, 1'b1, '1);
      step('0, 8'h04, 1'b0, '0);
      check("R9 pending untouched", reg_rdata, 32'h004);
      step('0, 8'h0C, 1'b0, '0);
      check("R9 mask untouched", reg_rdata, 32'h1FF);

      // R8: masking the only pending bit drops the request
      step('0, 8'h0C, 1'b1, 9'h1FB);
      check("R8 irq masked off", {31'h0, irq}, 32'h0);
      step('0, 8'h0C, 1'b1, 9'h004);
      check("R8 irq raised", {31'h0, irq}, 32'h1);

      // Random mix
      for (int k = 0; k < 600; k++) begin
         logic [7:0] a;
         logic [N-1:0] e;
         case ($urandom_range(0, 6))
            0: a = 8'h00;
            1: a = 8'h04;
            2: a = 8'h08;
            3: a = 8'h0C;
            4: a = 8'h10;
            5: a = 8'h14;
            default: a = 8'h10;
         endcase
         e = N'($urandom) & N'($urandom) & N'($urandom);
         step(e, a, ($urandom_range(0, 2) == 0), N'($urandom));
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule